// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block computes the effective address of a memory operand. It takes a mode code, a base register value, an index register value, a 16-bit signed offset and an operand size. It returns the address together with a done pulse. For the two stepping modes, it also returns an update for the base register: one mode steps the base up after use and the other steps it down before use.

One mode uses the base as a pointer to a pointer. In that mode the block sends its own read request to memory and waits for the returned word. That word is then presented as the final address. Every other mode finishes one cycle after the request is accepted.

The register file, the instruction decoder and the operand access that follows are outside this block.

Top module: `eff_addr_gen`

## Requirements
- R1: After reset, `done`, `busy`, `mem_req` and `wb_en` are all low.
- R2: Register-indirect mode (`mode`=0) gives `ea` equal to `base_val`.
- R3: Offset mode (`mode`=1) gives `ea` equal to `base_val` plus `disp` sign-extended from 16 to 32 bits.
- R4: Indexed mode (`mode`=2) gives `ea` equal to `base_val` + `index_val`. Absolute mode (`mode`=3) gives `ea` equal to the sign-extended `disp` alone.
- R5: Scaled mode (`mode`=7) gives `ea` equal to `base_val` + sign-extended `disp` + `index_val` times the operand size.
  - The operand size comes from `size_code`: 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes.
  - The scaling is a left shift of 0, 1 or 2 bits.
- R6: Post-increment mode (`mode`=5) gives `ea` equal to `base_val`, with `wb_en` high and `wb_val` equal to `base_val` + size.
- R7: Pre-decrement mode (`mode`=6) gives `ea` and `wb_val` both equal to `base_val` - size, with `wb_en` high.
- R8: In every mode other than 5 and 6, `wb_en` is low when `done` is high.
- R9: A request is accepted when `start` is high and `busy` is low. For any mode other than 4, the request raises `done` for one cycle on the next clock edge, with `ea` valid.
- R10: Pointer mode (`mode`=4) behaves as follows after acceptance:
  - On the next edge, `busy` and `mem_req` go high, with `mem_addr` equal to `base_val`.
  - Both stay high, and `mem_addr` stays steady, until `mem_rvalid` is sampled high.
- R11: On the edge where `mem_rvalid` is seen during a read, the block ends the read:
  - `busy` and `mem_req` drop.
  - `done` rises with `ea` equal to `mem_rdata`.
  - `wb_en` stays low.
- R12: A `start` that arrives while `busy` is high is ignored. It produces no `done` and does not change the pending result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe |
| mode | input | 3 | Addressing mode code |
| base_val | input | 32 | Base register value |
| index_val | input | 32 | Index register value |
| disp | input | 16 | Signed offset |
| size_code | input | 2 | Operand size code |
| busy | output | 1 | Pointer read in progress |
| done | output | 1 | Result valid pulse |
| ea | output | 32 | Effective address |
| wb_en | output | 1 | Base register update enable |
| wb_val | output | 32 | New base register value |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data |

## Verification
A wrong adder term or shift count shows up on `ea` or `wb_val` in the very next `done` cycle, so each mode is tested with values whose sums differ in every term. The pointer-mode state machine is checked in three ways:
- A stuck busy flag shows as a missing `done`.
- A busy flag that clears too early shows as `done` with the wrong `ea` before `mem_rvalid`.
- Both faults are visible within the read latency.

Starts issued during a read expose a missing `busy` guard through a stray `done` pulse.

// File: rtl/eff_addr_gen.sv
module eff_addr_gen #(
  parameter int AW = 32,
  parameter int DW = 16,
  parameter int MW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [MW-1:0] mode,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] index_val,
  input  logic [DW-1:0] disp,
  input  logic [1:0]    size_code,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] ea,
  output logic          wb_en,
  output logic [AW-1:0] wb_val,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [AW-1:0] mem_rdata
);
  localparam logic [MW-1:0] M_REG  = MW'(0);
  localparam logic [MW-1:0] M_OFS  = MW'(1);
  localparam logic [MW-1:0] M_IDX  = MW'(2);
  localparam logic [MW-1:0] M_ABS  = MW'(3);
  localparam logic [MW-1:0] M_PTR  = MW'(4);
  localparam logic [MW-1:0] M_INC  = MW'(5);
  localparam logic [MW-1:0] M_DEC  = MW'(6);
  localparam logic [MW-1:0] M_SCL  = MW'(7);

  logic [AW-1:0] dext, step, scaled, nxt_ea, nxt_wb;
  logic [1:0]    sh;
  logic          nxt_wben;

  assign dext   = {{(AW-DW){disp[DW-1]}}, disp};
  assign sh     = (size_code == 2'd0) ? 2'd0 : (size_code == 2'd1) ? 2'd1 : 2'd2;
  assign step   = {{(AW-1){1'b0}}, 1'b1} << sh;
  assign scaled = index_val << sh;
  assign mem_req = busy;

  always_comb begin
    nxt_ea   = base_val;
    nxt_wb   = base_val;
    nxt_wben = 1'b0;
    case (mode)
      M_OFS: nxt_ea = base_val + dext;
      M_IDX: nxt_ea = base_val + index_val;
      M_ABS: nxt_ea = dext;
      M_INC: begin
        nxt_wb   = base_val + step;
        nxt_wben = 1'b1;
      end
      M_DEC: begin
        nxt_ea   = base_val - step;
        nxt_wb   = base_val - step;
        nxt_wben = 1'b1;
      end
      M_SCL: nxt_ea = base_val + dext + scaled;
      default: nxt_ea = base_val;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      wb_en    <= 1'b0;
      ea       <= '0;
      wb_val   <= '0;
      mem_addr <= '0;
    end else begin
      done  <= 1'b0;
      wb_en <= 1'b0;
      if (busy) begin
        if (mem_rvalid) begin
          busy <= 1'b0;
          done <= 1'b1;
          ea   <= mem_rdata;
        end
      end else if (start) begin
        if (mode == M_PTR) begin
          busy     <= 1'b1;
          mem_addr <= base_val;
        end else begin
          done   <= 1'b1;
          ea     <= nxt_ea;
          wb_en  <= nxt_wben;
          wb_val <= nxt_wb;
        end
      end
    end
  end
endmodule

// File: rtl/eff_addr_gen_chk.sv
module eff_addr_gen_chk #(
  parameter int AW = 32,
  parameter int MW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [MW-1:0] mode,
  input logic [AW-1:0] base_val,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] ea,
  input logic          wb_en,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rvalid,
  input logic [AW-1:0] mem_rdata
);
  localparam logic [MW-1:0] PTR = MW'(4);
  localparam logic [MW-1:0] INC = MW'(5);
  localparam logic [MW-1:0] DEC = MW'(6);

  assert_fast_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && mode != PTR |=> done && !busy);
  assert_ptr_issue_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && mode == PTR |=> mem_req && busy && !done && mem_addr == $past(base_val));
  assert_ptr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr) && !done);
  assert_ptr_finish_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_rvalid |=> done && !busy && !wb_en && ea == $past(mem_rdata));
  assert_wb_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && mode != INC && mode != DEC |=> !wb_en);
  assert_no_start_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mem_rvalid |=> !done);
endmodule

bind eff_addr_gen eff_addr_gen_chk #(.AW(AW), .MW(MW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .base_val(base_val),
  .busy(busy), .done(done), .ea(ea), .wb_en(wb_en), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
);

// File: tb/eff_addr_gen_test.sv
`timescale 1ns/1ps
module eff_addr_gen_test;
  logic clk = 0, rst_n = 0, start = 0, mem_rvalid = 0;
  logic [2:0] mode = 0;
  logic [31:0] base_val = 0, index_val = 0, mem_rdata = 0;
  logic [15:0] disp = 0;
  logic [1:0] size_code = 0;
  logic busy, done, wb_en, mem_req;
  logic [31:0] ea, wb_val, mem_addr;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  eff_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .base_val(base_val),
    .index_val(index_val), .disp(disp), .size_code(size_code), .busy(busy),
    .done(done), .ea(ea), .wb_en(wb_en), .wb_val(wb_val), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] sx(input logic [15:0] d);
    return {{16{d[15]}}, d};
  endfunction

  function automatic logic [31:0] bytes_of(input logic [1:0] sc);
    return (sc == 0) ? 32'd1 : (sc == 1) ? 32'd2 : 32'd4;
  endfunction

  task automatic run_simple(input string tag, input logic [2:0] m, input logic [31:0] b,
                            input logic [31:0] x, input logic [15:0] d, input logic [1:0] sc,
                            input logic [31:0] exp_ea, input logic exp_wen,
                            input logic [31:0] exp_wv);
    @(negedge clk);
    mode = m; base_val = b; index_val = x; disp = d; size_code = sc; start = 1;
    @(negedge clk);
    start = 0;
    chk({tag, " R9 done"}, {31'd0, done}, 32'd1);
    chk({tag, " ea"}, ea, exp_ea);
    chk({tag, " R8 wb_en"}, {31'd0, wb_en}, {31'd0, exp_wen});
    if (exp_wen) chk({tag, " wb_val"}, wb_val, exp_wv);
    @(negedge clk);
    chk({tag, " R9 one-cycle done"}, {31'd0, done}, 32'd0);
  endtask

  task automatic run_ptr(input string tag, input logic [31:0] b, input logic [31:0] ptr,
                         input int wait_cycles, input logic poke);
    @(negedge clk);
    mode = 3'd4; base_val = b; start = 1;
    @(negedge clk);
    start = 0;
    chk({tag, " R10 req"}, {30'd0, mem_req, busy}, 32'd3);
    chk({tag, " R10 addr"}, mem_addr, b);
    for (int i = 0; i < wait_cycles; i++) begin
      if (poke) begin
        mode = 3'd1; base_val = 32'h0000_1000; disp = 16'h0010; start = 1;
      end
      @(negedge clk);
      start = 0;
      chk({tag, " R12 no done while busy"}, {31'd0, done}, 32'd0);
      chk({tag, " R10 hold"}, {31'd0, mem_req}, 32'd1);
      chk({tag, " R10 addr stable"}, mem_addr, b);
    end
    mem_rvalid = 1; mem_rdata = ptr;
    @(negedge clk);
    mem_rvalid = 0; mem_rdata = 32'hDEAD_BEEF;
    chk({tag, " R11 done"}, {31'd0, done}, 32'd1);
    chk({tag, " R11 ea"}, ea, ptr);
    chk({tag, " R11 wb_en"}, {31'd0, wb_en}, 32'd0);
    chk({tag, " R11 idle"}, {30'd0, mem_req, busy}, 32'd0);
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {28'd0, done, busy, mem_req, wb_en}, 32'd0);
    rst_n = 1;
    run_simple("R2 reg", 3'd0, 32'h1234_5678, 32'h99, 16'h7, 2'd2, 32'h1234_5678, 0, 0);
    run_simple("R3 ofs pos", 3'd1, 32'h0000_1000, 0, 16'h0123, 2'd0, 32'h0000_1123, 0, 0);
    run_simple("R3 ofs neg", 3'd1, 32'h0000_1000, 0, 16'hFFF0, 2'd0, 32'h0000_0FF0, 0, 0);
    run_simple("R4 idx", 3'd2, 32'h0000_2000, 32'h0000_0345, 16'h1, 2'd0, 32'h0000_2345, 0, 0);
    run_simple("R4 abs", 3'd3, 32'hFFFF_0000, 32'h5, 16'h8004, 2'd0, sx(16'h8004), 0, 0);
    for (int sc = 0; sc < 4; sc++)
      run_simple("R5 scaled", 3'd7, 32'h0000_4000, 32'h0000_0010, 16'hFFFE, 2'(sc),
                 32'h0000_4000 + sx(16'hFFFE) + 32'h10 * bytes_of(2'(sc)), 0, 0);
    for (int sc = 0; sc < 3; sc++)
      run_simple("R6 postinc", 3'd5, 32'h0000_0100, 0, 16'h55, 2'(sc),
                 32'h0000_0100, 1, 32'h100 + bytes_of(2'(sc)));
    for (int sc = 0; sc < 3; sc++)
      run_simple("R7 predec", 3'd6, 32'h0000_0100, 0, 16'h55, 2'(sc),
                 32'h100 - bytes_of(2'(sc)), 1, 32'h100 - bytes_of(2'(sc)));
    run_simple("R7 wrap", 3'd6, 32'h0000_0001, 0, 0, 2'd2, 32'hFFFF_FFFD, 1, 32'hFFFF_FFFD);
    run_ptr("R10 ptr immediate", 32'h0000_8000, 32'hCAFE_0000, 0, 0);
    run_ptr("R10 ptr slow", 32'h0000_9000, 32'h0BAD_F00D, 4, 0);
    run_ptr("R12 ptr poked", 32'h0000_A000, 32'h1357_9BDF, 3, 1);
    run_simple("R8 after ptr", 3'd1, 32'h10, 0, 16'h4, 2'd0, 32'h14, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule